// File: doc/BRIEF.md
# Multi-Line DMA Transmit Scheduler

This block schedules transmit DMA for a group of serial lines. Each line has its own transfer context: an 18-bit current address and a 16-bit byte count. Software reaches these through a small register window. It selects a line with a field in the control word, writes that line's address and count, and then sets the line's bit in a shared active mask. The engine visits the active lines in turn. On each visit it reads one byte from memory and hands that byte, tagged with the line number, to the serial shifters through a ready/valid handshake.

The byte count holds the two's-complement negative of the transfer length and counts up towards zero. When a line's count reaches zero, the hardware clears that line's active bit and raises a transmit-done flag. That flag can drive an interrupt. Software can cut a transfer short by writing all-ones to the count: at most one more byte is then fetched, and the address register shows where the transfer stopped. A memory read that returns an error sets a sticky flag and retires the line.

Register window, selected by `reg_addr`: 0 is the control word, 1 is the low 16 address bits of the selected line, 2 is the count of the selected line, and 3 is the active mask (bit n stands for line n). Reads are combinational.

Top module: `txdma_sched`

## Requirements
- R1: After reset, every register reads zero, `mem_req`, `tx_valid` and `irq` are low, and no line is active.
- R2: Writing the control word sets the line select from bits 3:0 and stores bits 5:4 as address bits 17:16 of the newly selected line. Register windows 1 and 2 read and write only the selected line's address and count. Reading the control word returns that line's bits 17:16 in bits 5:4 and the select in bits 3:0.
- R3: A fetch presents the 18-bit address {bits 17:16, low 16 bits} and holds it until `mem_ack` or `mem_err`. Each fetched byte advances the full 18-bit address by one, with the carry passing into bits 17:16, and advances the count by one.
- R4: A fetched byte appears on `tx_data` with its line on `tx_line`. `tx_valid` stays high and both values stay stable until `tx_ready` is seen high.
- R5: Active lines are served one byte per turn, in round-robin order. The search starts at the line after the one served last.
- R6: When a line's count is zero after one of its bytes is accepted, its active bit clears and control bit 15 is set. `irq` equals bit 15 AND bit 13. A control write with bit 15 at 0 clears bit 15.
- R7: A line that is activated while its count is already zero is retired without any fetch, and bit 15 is set.
- R8: After all-ones is written to a busy line's count, that line fetches at most one more byte. It then retires, and its address reads one past the last byte fetched.
- R9: `mem_err` during a fetch sets control bit 10, clears that line's active bit and emits no byte. A control write with bit 8 at 1 clears bit 10.
- R10: A hardware clear of an active bit wins over a software write of the active mask in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register window select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| mem_req | output | 1 | Memory byte read request |
| mem_addr | output | 18 | Memory byte address |
| mem_ack | input | 1 | Read data valid for the pending request |
| mem_err | input | 1 | Pending request hit non-existent memory |
| mem_rdata | input | 8 | Read data byte |
| tx_valid | output | 1 | Byte available for the shifters |
| tx_ready | input | 1 | Shifters accept the byte |
| tx_data | output | 8 | Byte to transmit |
| tx_line | output | 4 | Line the byte belongs to |
| irq | output | 1 | Transmit-done interrupt request |

## Verification
The bench targets several corner cases.

- **Address carry.** One buffer starts two bytes below a 64 KiB boundary. A design that drops the carry into bits 17:16 would wrap the address and fetch the wrong bytes.
- **Round-robin order.** Three lines are started together. A fixed-priority arbiter would emit them in the wrong sequence.
- **Stop by count write.** A line is stalled at the output while all-ones is written to its count. A design that lets the in-flight update overwrite the software write would run on to the full length.
- **Zero-count start.** A line started with a zero count must not issue any fetch. A design that fetches first would wrap the count and run 65536 bytes.
- **Error and clear race.** A memory error must retire its line and set the flag without emitting a byte. A software write of the mask in the same cycle as a hardware clear must not bring the finished line back to life.

// File: rtl/txdma_pkg.sv
`timescale 1ns/1ps
package txdma_pkg;
    typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_FETCH = 2'd1, ST_SEND = 2'd2} eng_st_e;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_ADDR = 2'd1;
    localparam logic [1:0] RA_CNT  = 2'd2;
    localparam logic [1:0] RA_ACT  = 2'd3;

    localparam int CB_EXT   = 4;
    localparam int CB_CLRNX = 8;
    localparam int CB_NXM   = 10;
    localparam int CB_TIE   = 13;
    localparam int CB_TI    = 15;
endpackage

// File: rtl/txdma_rr_arb.sv
`timescale 1ns/1ps
module txdma_rr_arb #(
    parameter int N  = 16,
    parameter int LW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [LW-1:0] last,
    output logic [LW-1:0] gnt,
    output logic          gnt_ok
);
    always_comb begin
        gnt    = '0;
        gnt_ok = 1'b0;
        for (int i = 1; i <= N; i++) begin
            if (!gnt_ok && req[(int'(last) + i) % N]) begin
                gnt_ok = 1'b1;
                gnt    = LW'((int'(last) + i) % N);
            end
        end
    end
endmodule

// File: rtl/txdma_sched.sv
`timescale 1ns/1ps
module txdma_sched
    import txdma_pkg::*;
#(
    parameter int NLINES = 16,
    parameter int ALO_W  = 16,
    parameter int AHI_W  = 2,
    parameter int CNT_W  = 16,
    parameter int DW     = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             reg_wr,
    input  logic [1:0]                       reg_addr,
    input  logic [15:0]                      reg_wdata,
    output logic [15:0]                      reg_rdata,
    output logic                             mem_req,
    output logic [AHI_W+ALO_W-1:0]           mem_addr,
    input  logic                             mem_ack,
    input  logic                             mem_err,
    input  logic [DW-1:0]                    mem_rdata,
    output logic                             tx_valid,
    input  logic                             tx_ready,
    output logic [DW-1:0]                    tx_data,
    output logic [$clog2(NLINES)-1:0]        tx_line,
    output logic                             irq
);
    localparam int LW = $clog2(NLINES);
    localparam int AW = AHI_W + ALO_W;

    typedef struct packed {
        eng_st_e                        st;
        logic [LW-1:0]                  sel;
        logic [LW-1:0]                  cur;
        logic [LW-1:0]                  last;
        logic [NLINES-1:0]              act;
        logic                           ti;
        logic                           tie;
        logic                           nxm;
        logic [DW-1:0]                  data;
        logic [NLINES-1:0][ALO_W-1:0]   alo;
        logic [NLINES-1:0][AHI_W-1:0]   ahi;
        logic [NLINES-1:0][CNT_W-1:0]   cnt;
    } state_t;

    state_t q, d;

    logic [LW-1:0]     gnt;
    logic              gnt_ok;
    logic [NLINES-1:0] hw_clr;
    logic              set_ti, set_nxm, ti_b, nxm_b;
    logic [NLINES-1:0] act_b;
    logic              fin_now;

    txdma_rr_arb #(.N(NLINES), .LW(LW)) u_arb (
        .req(q.act), .last(q.last), .gnt(gnt), .gnt_ok(gnt_ok)
    );

    assign fin_now = (q.st == ST_SEND) && tx_ready && (q.cnt[q.cur] == '0);

    always_comb begin
        d       = q;
        hw_clr  = '0;
        set_ti  = 1'b0;
        set_nxm = 1'b0;
        act_b   = q.act;
        ti_b    = q.ti;
        nxm_b   = q.nxm;
        // engine
        case (q.st)
            ST_IDLE: begin
                if (gnt_ok) begin
                    if (q.cnt[gnt] == '0) begin
                        hw_clr[gnt] = 1'b1;
                        set_ti      = 1'b1;
                        d.last      = gnt;
                    end else begin
                        d.cur = gnt;
                        d.st  = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                if (mem_err) begin
                    set_nxm       = 1'b1;
                    hw_clr[q.cur] = 1'b1;
                    d.last        = q.cur;
                    d.st          = ST_IDLE;
                end else if (mem_ack) begin
                    d.data = mem_rdata;
                    {d.ahi[q.cur], d.alo[q.cur]} = {q.ahi[q.cur], q.alo[q.cur]} + AW'(1);
                    d.cnt[q.cur] = q.cnt[q.cur] + CNT_W'(1);
                    d.st   = ST_SEND;
                end
            end
            ST_SEND: begin
                if (tx_ready) begin
                    if (q.cnt[q.cur] == '0) begin
                        hw_clr[q.cur] = 1'b1;
                        set_ti        = 1'b1;
                    end
                    d.last = q.cur;
                    d.st   = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
        // software writes override the engine's context updates
        if (reg_wr) begin
            case (reg_addr)
                RA_CTRL: begin
                    d.sel = reg_wdata[LW-1:0];
                    d.ahi[reg_wdata[LW-1:0]] = reg_wdata[CB_EXT +: AHI_W];
                    d.tie = reg_wdata[CB_TIE];
                    ti_b  = q.ti & reg_wdata[CB_TI];
                    if (reg_wdata[CB_CLRNX]) nxm_b = 1'b0;
                end
                RA_ADDR: d.alo[q.sel] = reg_wdata[ALO_W-1:0];
                RA_CNT:  d.cnt[q.sel] = reg_wdata[CNT_W-1:0];
                default: act_b = reg_wdata[NLINES-1:0];
            endcase
        end
        // hardware clear and flag set take priority
        d.act = act_b & ~hw_clr;
        d.ti  = ti_b | set_ti;
        d.nxm = nxm_b | set_nxm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_CTRL: begin
                reg_rdata[LW-1:0]             = q.sel;
                reg_rdata[CB_EXT +: AHI_W]    = q.ahi[q.sel];
                reg_rdata[CB_NXM]             = q.nxm;
                reg_rdata[CB_TIE]             = q.tie;
                reg_rdata[CB_TI]              = q.ti;
            end
            RA_ADDR: reg_rdata = 16'(q.alo[q.sel]);
            RA_CNT:  reg_rdata = 16'(q.cnt[q.sel]);
            default: reg_rdata = 16'(q.act);
        endcase
    end

    assign mem_req  = (q.st == ST_FETCH);
    assign mem_addr = {q.ahi[q.cur], q.alo[q.cur]};
    assign tx_valid = (q.st == ST_SEND);
    assign tx_data  = q.data;
    assign tx_line  = q.cur;
    assign irq      = q.ti & q.tie;

    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !mem_err && !reg_wr) |=> (mem_req && $stable(mem_addr)));

    assert_tx_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_line)));

    assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_now |=> q.ti);

    // also covers R10: the clear holds whatever software wrote to the mask
    assert_done_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fin_now |=> !q.act[$past(q.cur)]);

    assert_nxm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_err) |=> (q.nxm && !tx_valid));
endmodule

// File: tb/sim_txdma_sched.sv
`timescale 1ns/1ps
module sim_txdma_sched;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        mem_req;
    logic [17:0] mem_addr;
    logic        mem_ack, mem_err;
    logic [7:0]  mem_rdata;
    logic        tx_valid;
    logic        tx_ready = 1'b1;
    logic [7:0]  tx_data;
    logic [3:0]  tx_line;
    logic        irq;

    int nerr = 0, ntot = 0, nfetch = 0, nlog = 0;
    logic [3:0] log_line [64];
    logic [7:0] log_data [64];

    always #2 clk = ~clk;

    txdma_sched u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_err(mem_err),
        .mem_rdata(mem_rdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_line(tx_line), .irq(irq)
    );

    // {line, ext, addr, len}
    localparam logic [29:0] VEC [4] = '{
        {4'd0,  2'd0, 16'h0100, 8'd3},
        {4'd5,  2'd1, 16'h2000, 8'd1},
        {4'd15, 2'd0, 16'hFFFE, 8'd3},
        {4'd9,  2'd2, 16'h0040, 8'd4}
    };

    function automatic logic [7:0] mdat(logic [17:0] a);
        return a[7:0] ^ {a[15:10], a[17:16]};
    endfunction

    // memory model: top address bits 11 are absent
    initial begin
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk); #1;
            mem_ack = 1'b0; mem_err = 1'b0;
            if (mem_req) begin
                if (mem_addr[17:16] == 2'b11) mem_err = 1'b1;
                else begin mem_ack = 1'b1; mem_rdata = mdat(mem_addr); end
                nfetch++;
            end
        end
    end

    initial forever begin
        @(negedge clk); #1;
        if (tx_valid && tx_ready && nlog < 64) begin
            log_line[nlog] = tx_line; log_data[nlog] = tx_data; nlog++;
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", nerr, ntot);
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        ntot++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a; #1 v = reg_rdata;
    endtask

    task automatic prog(input logic [3:0] ln, input logic [1:0] ext,
                        input logic [15:0] a, input logic [7:0] len, input bit go);
        wr(2'd0, 16'h2000 | (16'(ext) << 4) | 16'(ln));
        wr(2'd1, a);
        wr(2'd2, -16'(len));
        if (go) wr(2'd3, 16'(1) << ln);
    endtask

    task automatic wait_idle();
        logic [15:0] v;
        for (int i = 0; i < 500; i++) begin
            rd(2'd3, v);
            if (v == 16'd0) break;
        end
    endtask

    task automatic wait_valid();
        for (int i = 0; i < 100; i++) begin
            @(negedge clk); #1;
            if (tx_valid) break;
        end
    endtask

    initial begin
        #(4 * 150000);
        nerr++; ntot++;
        $display("FAIL watchdog: actual=hung expected=finished");
        report();
        $finish;
    end

    initial begin
        logic [15:0] v;
        logic [17:0] base, fin;
        int bad, f0;
        logic [7:0] sd; logic [3:0] sl;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(!mem_req && !tx_valid && !irq, "R1 outputs", {mem_req, tx_valid, irq}, 0);
        for (int r = 0; r < 4; r++) begin
            rd(2'(r), v);
            chk(v == 16'd0, "R1 register", v, 0);
        end

        // table of buffers: R3 R4 R6
        for (int k = 0; k < 4; k++) begin
            nlog = 0;
            base = {VEC[k][25:24], VEC[k][23:8]};
            prog(VEC[k][29:26], VEC[k][25:24], VEC[k][23:8], VEC[k][7:0], 1'b1);
            wait_idle();
            bad = 0;
            for (int i = 0; i < nlog; i++)
                if (log_line[i] != VEC[k][29:26] || log_data[i] != mdat(base + 18'(i))) bad++;
            chk(nlog == int'(VEC[k][7:0]) && bad == 0, "R4 bytes and line", nlog, VEC[k][7:0]);
            fin = base + 18'(VEC[k][7:0]);
            rd(2'd1, v);
            chk(v == fin[15:0], "R3 final address", v, fin[15:0]);
            rd(2'd0, v);
            chk(v[5:4] == fin[17:16] && v[15], "R3 ext bits and R6 flag", v, {fin[17:16], 4'h0});
            rd(2'd2, v);
            chk(v == 16'd0, "R3 count at zero", v, 0);
            chk(irq, "R6 irq raised", irq, 1);
        end
        wr(2'd0, 16'h2009);
        rd(2'd0, v);
        chk(!v[15] && !irq, "R6 flag cleared by writing 0", v[15], 0);

        // R5 round robin: last served is line 9
        nlog = 0;
        prog(4'd2, 2'd0, 16'h0300, 8'd2, 1'b0);
        prog(4'd7, 2'd0, 16'h0400, 8'd2, 1'b0);
        prog(4'd11, 2'd0, 16'h0600, 8'd2, 1'b0);
        wr(2'd3, 16'h0884);
        wait_idle();
        chk(nlog == 6 && log_line[0] == 4'd11 && log_line[1] == 4'd2 && log_line[2] == 4'd7
            && log_line[3] == 4'd11 && log_line[4] == 4'd2 && log_line[5] == 4'd7,
            "R5 service order", {log_line[0], log_line[1], log_line[2]}, 12'hB27);

        // R2 indirect context access
        wr(2'd0, 16'h0026); wr(2'd1, 16'h1234); wr(2'd2, 16'hABCD);
        wr(2'd0, 16'h0007); wr(2'd1, 16'h1111);
        wr(2'd0, 16'h0006);
        rd(2'd1, v); chk(v == 16'h1234, "R2 address of line 6", v, 16'h1234);
        rd(2'd2, v); chk(v == 16'hABCD, "R2 count of line 6", v, 16'hABCD);
        rd(2'd0, v); chk(v[5:0] == 6'h26 || v[5:0] == 6'h06, "R2 control select", v[5:0], 6'h06);
        wr(2'd0, 16'h0026);
        rd(2'd0, v); chk(v[5:0] == 6'h26, "R2 ext readback", v[5:0], 6'h26);

        // R7 zero count start, with TIE low
        f0 = nfetch;
        wr(2'd0, 16'h0004); wr(2'd2, 16'h0000); wr(2'd3, 16'h0010);
        wait_idle();
        rd(2'd0, v);
        chk(nfetch == f0 && v[15], "R7 no fetch and flag", nfetch - f0, 0);
        chk(!irq, "R6 irq masked by enable bit", irq, 0);

        // R8 stop by count write, R4 hold while stalled
        nlog = 0; tx_ready = 1'b0; f0 = nfetch;
        prog(4'd3, 2'd0, 16'h0500, 8'd10, 1'b1);
        wait_valid();
        sd = tx_data; sl = tx_line;
        repeat (3) @(negedge clk);
        #1 chk(tx_valid && tx_data == sd && tx_line == sl, "R4 stable while stalled", tx_data, sd);
        wr(2'd2, 16'hFFFF);
        @(negedge clk); tx_ready = 1'b1;
        wait_idle();
        rd(2'd1, v);
        chk(nfetch - f0 == 2 && nlog == 2, "R8 one more byte", nfetch - f0, 2);
        chk(v == 16'h0502, "R8 stop address", v, 16'h0502);

        // R9 non-existent memory
        nlog = 0;
        prog(4'd6, 2'd3, 16'h0000, 8'd2, 1'b1);
        wait_idle();
        rd(2'd0, v);
        chk(v[10] && nlog == 0, "R9 error flag, no byte", {v[10], 4'(nlog)}, 5'h10);
        wr(2'd0, 16'h0106);
        rd(2'd0, v);
        chk(!v[10], "R9 flag cleared", v[10], 0);

        // R10 hardware clear beats same-cycle mask write
        nlog = 0; tx_ready = 1'b0;
        prog(4'd1, 2'd0, 16'h0700, 8'd1, 1'b1);
        wait_valid();
        reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 16'h0002; tx_ready = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
        rd(2'd3, v);
        chk(v == 16'h0000 && nlog == 1, "R10 clear wins", v, 0);

        report();
        $finish;
    end
endmodule